// File: doc/BRIEF.md
# Pipeline Bypass and Load-Interlock Unit

This block watches the register fields of the instructions moving through a five-stage in-order integer pipeline (fetch, decode with register read, execute, memory, writeback). It chooses, for each of the two ALU inputs of the instruction now in execute, whether the operand comes from the register file, from the result held in the memory stage, or from the value being written back. Because registers are read only in decode and written only in writeback, the only hazard to resolve is read-after-write. Results from an ALU instruction reach a dependent successor through these bypass paths, so the successor does not stall.

A load's data is not ready until the end of the memory stage, so a bypass cannot cover an instruction that reads the loaded register straight after the load. The unit detects this case while the dependent instruction is still in decode and raises a stall. The stall holds the program counter and the fetch/decode register and loads a no-op into the decode/execute register. After that single bubble the load is in writeback and the normal writeback bypass supplies its data. Register 0 is a hardwired zero: a write to it never bypasses and never stalls.

The unit is purely combinational. The surrounding pipeline wires the decode source fields from instruction bits 25:21 (first source) and 20:16 (second source) and supplies the pipeline-register fields of the later stages.

Top module: `hz_fwd_unit`

## Requirements
- R1: When the memory-stage instruction has write enable high, a nonzero destination, and that destination equals an execute source, the select for that source is 2'b10.
- R2: When the writeback instruction has write enable high, a nonzero destination equal to an execute source, and R1 does not apply to that source, the select is 2'b01.
- R3: When the memory-stage and writeback instructions both match a source under R1 and R2, the memory stage wins and the select is 2'b10.
- R4: A destination of register 0, or a producer with write enable low, never causes a bypass; an execute source of 0 always selects 2'b00.
- R5: With no matching producer, the select is 2'b00 (register file value).
- R6: The first ALU input select `fwd_a` depends only on `ex_rs1` and the second `fwd_b` only on `ex_rs2`; each is resolved independently.
- R7: A stall is raised when the execute instruction is a load with write enable high and a nonzero destination equal to the decode first source (instruction bits 25:21) or decode second source (instruction bits 20:16).
- R8: No stall is raised for a non-load producer in execute, for a load writing register 0, or for a load with write enable low.
- R9: `hold_front` and `insert_bubble` are both high exactly when a stall is raised (R7) and both low otherwise; a load-use pair yields one stall cycle, after which the operand is bypassed from writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | 5 | Decode instruction first source (instr bits 25:21) |
| id_rs2 | input | 5 | Decode instruction second source (instr bits 20:16) |
| ex_rs1 | input | 5 | Execute instruction first source |
| ex_rs2 | input | 5 | Execute instruction second source |
| ex_rd | input | 5 | Execute instruction destination |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_rd | input | 5 | Memory-stage destination |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| wb_rd | input | 5 | Writeback destination |
| wb_wen | input | 1 | Writeback instruction writes a register |
| fwd_a | output | 2 | First ALU input source: 00 regfile, 01 writeback, 10 memory stage |
| fwd_b | output | 2 | Second ALU input source, same encoding |
| hold_front | output | 1 | Freeze PC and fetch/decode register |
| insert_bubble | output | 1 | Load a no-op into the decode/execute register |

## Verification
The assertions check on every input combination that a live memory-stage match forces the memory select even when writeback also matches, that a zero source never bypasses, that a load-use match always stalls and that a non-load never stalls. Only the bench scenarios show the full select encoding for both operands against an independent model, the writeback-only case, independence of the two operands, the zero-destination and disabled-write cases, and the decode fields taken from the correct instruction bit positions, including the single-bubble sequence around a load.

// File: rtl/hz_pkg.sv
package hz_pkg;

    typedef enum logic [1:0] {
        SRC_REGFILE = 2'b00,
        SRC_WBACK   = 2'b01,
        SRC_MEMSTG  = 2'b10
    } src_sel_e;

endpackage

// File: rtl/hz_src_fwd.sv
module hz_src_fwd
    import hz_pkg::*;
#(
    parameter int RW = 5
) (
    input  logic [RW-1:0] src,
    input  logic [RW-1:0] mem_rd,
    input  logic          mem_wen,
    input  logic [RW-1:0] wb_rd,
    input  logic          wb_wen,
    output src_sel_e      sel
);

    logic mem_hit;
    logic wb_hit;

    // A producer only counts when it really writes a nonzero register.
    assign mem_hit = mem_wen && (mem_rd != '0) && (mem_rd == src);
    assign wb_hit  = wb_wen  && (wb_rd  != '0) && (wb_rd  == src);

    always_comb begin
        unique case ({mem_hit, wb_hit})
            2'b10, 2'b11: sel = SRC_MEMSTG;   // younger result wins
            2'b01:        sel = SRC_WBACK;
            default:      sel = SRC_REGFILE;
        endcase
    end

endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
    parameter int RW = 5
) (
    input  logic [RW-1:0] id_rs1,
    input  logic [RW-1:0] id_rs2,
    input  logic [RW-1:0] ex_rd,
    input  logic          ex_wen,
    input  logic          ex_load,
    output logic          stall
);

    logic load_live;

    assign load_live = ex_load && ex_wen && (ex_rd != '0);
    assign stall     = load_live && ((ex_rd == id_rs1) || (ex_rd == id_rs2));

endmodule

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit
    import hz_pkg::*;
#(
    parameter int NREG = 32,
    parameter int RW   = $clog2(NREG)
) (
    input  logic [RW-1:0] id_rs1,
    input  logic [RW-1:0] id_rs2,
    input  logic [RW-1:0] ex_rs1,
    input  logic [RW-1:0] ex_rs2,
    input  logic [RW-1:0] ex_rd,
    input  logic          ex_wen,
    input  logic          ex_load,
    input  logic [RW-1:0] mem_rd,
    input  logic          mem_wen,
    input  logic [RW-1:0] wb_rd,
    input  logic          wb_wen,
    output logic [1:0]    fwd_a,
    output logic [1:0]    fwd_b,
    output logic          hold_front,
    output logic          insert_bubble
);

    localparam int NSRC = 2;

    logic [RW-1:0] ex_src [NSRC];
    src_sel_e      sel    [NSRC];
    logic          stall;

    assign ex_src[0] = ex_rs1;
    assign ex_src[1] = ex_rs2;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        hz_src_fwd #(.RW(RW)) u_fwd (
            .src     (ex_src[g]),
            .mem_rd  (mem_rd),
            .mem_wen (mem_wen),
            .wb_rd   (wb_rd),
            .wb_wen  (wb_wen),
            .sel     (sel[g])
        );
    end

    hz_load_use #(.RW(RW)) u_lu (
        .id_rs1  (id_rs1),
        .id_rs2  (id_rs2),
        .ex_rd   (ex_rd),
        .ex_wen  (ex_wen),
        .ex_load (ex_load),
        .stall   (stall)
    );

    assign fwd_a         = sel[0];
    assign fwd_b         = sel[1];
    assign hold_front    = stall;
    assign insert_bubble = stall;

endmodule

// File: rtl/hz_fwd_unit_chk.sv
module hz_fwd_unit_chk #(
    parameter int RW = 5
) (
    input logic [RW-1:0] id_rs1,
    input logic [RW-1:0] id_rs2,
    input logic [RW-1:0] ex_rs1,
    input logic [RW-1:0] ex_rs2,
    input logic [RW-1:0] ex_rd,
    input logic          ex_wen,
    input logic          ex_load,
    input logic [RW-1:0] mem_rd,
    input logic          mem_wen,
    input logic [RW-1:0] wb_rd,
    input logic          wb_wen,
    input logic [1:0]    fwd_a,
    input logic [1:0]    fwd_b,
    input logic          hold_front,
    input logic          insert_bubble
);

    always_comb begin
        // R1 / R3: a live memory-stage match wins on operand A
        if (mem_wen && mem_rd != '0 && mem_rd == ex_rs1)
            a_r3_mem_wins_a: assert (fwd_a == 2'b10) else $error("a_r3_mem_wins_a");
        // R1: same for operand B
        if (mem_wen && mem_rd != '0 && mem_rd == ex_rs2)
            a_r1_mem_fwd_b: assert (fwd_b == 2'b10) else $error("a_r1_mem_fwd_b");
        // R4: register 0 is never bypassed
        if (ex_rs1 == '0)
            a_r4_zero_src_a: assert (fwd_a == 2'b00) else $error("a_r4_zero_src_a");
        if (ex_rs2 == '0)
            a_r4_zero_src_b: assert (fwd_b == 2'b00) else $error("a_r4_zero_src_b");
        // R7: load-use always stalls
        if (ex_load && ex_wen && ex_rd != '0 && (ex_rd == id_rs1 || ex_rd == id_rs2))
            a_r7_load_use: assert (hold_front && insert_bubble) else $error("a_r7_load_use");
        // R8: only loads stall
        if (!ex_load)
            a_r8_alu_no_stall: assert (!hold_front && !insert_bubble) else $error("a_r8_alu_no_stall");
    end

endmodule

bind hz_fwd_unit hz_fwd_unit_chk #(.RW(RW)) u_chk (.*);

// File: tb/tb_hz_fwd_unit.sv
`timescale 1ns/1ps
module tb_hz_fwd_unit;

    localparam int RW = 5;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic [RW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
    logic          ex_wen, ex_load, mem_wen, wb_wen;
    logic [1:0]    fwd_a, fwd_b;
    logic          hold_front, insert_bubble;

    hz_fwd_unit dut (.*);

    typedef struct {
        logic [1:0] a;
        logic [1:0] b;
        logic       st;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   drv_done = 0;

    // Independent reference: scan oldest to youngest, younger overwrites.
    function automatic logic [1:0] ref_sel(logic [RW-1:0] s,
                                           logic [RW-1:0] mrd, logic mw,
                                           logic [RW-1:0] wrd, logic ww);
        logic [1:0] r;
        r = 2'b00;
        if (s != 0) begin
            if (ww && wrd == s) r = 2'b01;
            if (mw && mrd == s) r = 2'b10;
        end
        return r;
    endfunction

    // Register-register word: src1 at 25:21, src2 at 20:16, dest at 15:11
    function automatic logic [31:0] rr(logic [4:0] s1, logic [4:0] s2, logic [4:0] d);
        return {6'h00, s1, s2, d, 11'h000};
    endfunction

    task automatic vec(input logic [31:0] idw,
                       input logic [4:0] xs1, input logic [4:0] xs2,
                       input logic [4:0] xd, input logic xw, input logic xl,
                       input logic [4:0] md, input logic mw,
                       input logic [4:0] wd, input logic ww,
                       input string tag);
        exp_t e;
        @(negedge clk);
        id_rs1 = idw[25:21]; id_rs2 = idw[20:16];
        ex_rs1 = xs1; ex_rs2 = xs2; ex_rd = xd; ex_wen = xw; ex_load = xl;
        mem_rd = md; mem_wen = mw; wb_rd = wd; wb_wen = ww;
        e.a   = ref_sel(xs1, md, mw, wd, ww);
        e.b   = ref_sel(xs2, md, mw, wd, ww);
        e.st  = xl && xw && (xd != 0) && (xd == idw[25:21] || xd == idw[20:16]);
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Monitor: inputs change at negedge, compare at posedge.
    always @(posedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(fwd_a == e.a, e.tag, "fwd_a", fwd_a, e.a);
            chk(fwd_b == e.b, e.tag, "fwd_b", fwd_b, e.b);
            chk(hold_front == e.st, e.tag, "hold_front", hold_front, e.st);
            chk(insert_bubble == e.st, e.tag, "insert_bubble", insert_bubble, e.st);
        end
    end

    task automatic drive_all();
        // R5: idle pipeline, nothing matches
        vec(rr(0,0,0), 0,0, 0,0,0, 0,0, 0,0, "R5_idle");
        vec(rr(1,2,3), 4,5, 6,1,0, 7,1, 8,1, "R5_no_match");
        // R1: memory-stage forward on each operand
        vec(rr(0,0,0), 3,9, 0,0,0, 3,1, 0,0, "R1_mem_a");
        vec(rr(0,0,0), 9,3, 0,0,0, 3,1, 0,0, "R1_mem_b");
        // R2: writeback forward
        vec(rr(0,0,0), 7,7, 0,0,0, 0,0, 7,1, "R2_wb_both");
        vec(rr(0,0,0), 7,6, 0,0,0, 5,1, 7,1, "R2_wb_a_only");
        // R3: both match, memory stage wins
        vec(rr(0,0,0), 4,4, 0,0,0, 4,1, 4,1, "R3_mem_priority");
        vec(rr(0,0,0), 4,2, 0,0,0, 2,1, 4,1, "R3_split");
        // R4: zero destination / disabled writes
        vec(rr(0,0,0), 0,0, 0,0,0, 0,1, 0,1, "R4_reg0");
        vec(rr(0,0,0), 5,6, 0,0,0, 5,0, 6,0, "R4_wen_low");
        vec(rr(0,0,0), 5,5, 0,0,0, 5,0, 5,1, "R4_mem_off_wb_on");
        // R6: operands independent
        vec(rr(0,0,0), 10,11, 0,0,0, 11,1, 10,1, "R6_indep");
        // R7: load-use on each decode field position
        vec(rr(9,1,2), 0,0, 9,1,1, 0,0, 0,0, "R7_lu_src1_bits25_21");
        vec(rr(1,9,2), 0,0, 9,1,1, 0,0, 0,0, "R7_lu_src2_bits20_16");
        vec(rr(1,2,9), 0,0, 9,1,1, 0,0, 0,0, "R7_dest_field_no_stall");
        // R8: no stall for ALU producer, reg0 load, disabled load
        vec(rr(9,9,0), 0,0, 9,1,0, 0,0, 0,0, "R8_alu");
        vec(rr(0,0,0), 0,0, 0,1,1, 0,0, 0,0, "R8_load_r0");
        vec(rr(9,0,0), 0,0, 9,0,1, 0,0, 0,0, "R8_load_wen_low");
        // R9: load x3 ; add x4,x3,x1 -- stall cycle, then bubble in EX,
        // load in WB, dependent in EX bypassed from writeback.
        vec(rr(3,1,4), 0,0, 3,1,1, 0,0, 0,0, "R9_seq_stall");
        vec(rr(3,1,4), 0,0, 0,0,0, 3,1, 0,0, "R9_seq_bubble_no_stall");
        vec(rr(0,0,0), 3,1, 0,0,0, 0,0, 3,1, "R9_seq_wb_bypass");
        // Mixed sweep with a small register range to force collisions
        for (int i = 0; i < 400; i++) begin
            vec(rr(5'($urandom_range(0,3)), 5'($urandom_range(0,3)), 5'($urandom_range(0,3))),
                5'($urandom_range(0,3)), 5'($urandom_range(0,3)),
                5'($urandom_range(0,3)), 1'($urandom_range(0,1)), 1'($urandom_range(0,1)),
                5'($urandom_range(0,3)), 1'($urandom_range(0,1)),
                5'($urandom_range(0,3)), 1'($urandom_range(0,1)),
                "R6_R7_sweep");
        end
        drv_done = 1;
    endtask

    initial begin
        id_rs1 = 0; id_rs2 = 0; ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0;
        ex_wen = 0; ex_load = 0; mem_rd = 0; mem_wen = 0; wb_rd = 0; wb_wen = 0;
        #1;
        // Reset state: quiet inputs give regfile selects and no stall (R5)
        chk(fwd_a == 2'b00 && fwd_b == 2'b00, "R5_initial", "sel",
            {fwd_a, fwd_b}, 0);
        chk(!hold_front && !insert_bubble, "R8_initial", "stall",
            {hold_front, insert_bubble}, 0);
        fork
            begin
                drive_all();
                while (q.size() > 0) @(negedge clk);
                repeat (2) @(negedge clk);
            end
            begin
                repeat (20000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule